// File: doc/BRIEF.md
# Full-Speed USB Receive Bit Recovery

This block turns the raw D+ and D- wires of a full-speed USB link into a stream of decoded bits. It runs on a clock at eight times the bit rate. Both wires pass through a two-flop synchroniser. An edge detector watches the synchronised D+. A bit-period timer produces one sample strobe per bit, and an NRZI decoder turns each sampled level into a data bit. A combinational detector flags the single-ended-zero state that ends a packet.

The timer does not use a phase-locked loop. Every D+ transition throws away the current count. Three cycles later the timer issues a strobe, which falls near the middle of the bit, and it then free-runs with an eight-cycle period until the next transition. A downstream byte assembler takes `bit_value` in each cycle where `bit_strobe` is high, and it holds `rx_active` high for as long as it expects packet bits.

Top module: `fs_bit_recover`

## Requirements
- R1: Each change of `dp_raw` gives exactly one single-cycle pulse on `dp_edge`. The pulse is visible two clock edges after the change, once the change has passed the two-flop synchroniser.
- R2: `eop` is high whenever the synchronised D+ and D- are both low. It rises two clock edges after both raw wires go low and falls two clock edges after either wire goes high.
- R3: While `rx_active` is high and no D+ edge occurs, `bit_strobe` pulses exactly once every 8 clock cycles.
- R4: When a D+ edge occurs with `rx_active` high, the timer drops its count. The next strobe comes exactly 3 cycles after the `dp_edge` cycle, and R3 spacing resumes from that strobe.
- R5: In a strobe cycle, `bit_value` is 1 when the synchronised D+ equals the level kept from the previous strobe, and 0 when the two differ (NRZI: transition means 0).
- R6: The kept D+ level is updated only in strobe cycles.
- R7: While `rx_active` is low the timer is held at zero and no strobe is issued. After `rx_active` rises with no edge, the first strobe falls in the fourth cycle with `rx_active` high.
- R8: On reset the outputs are idle, the synchroniser holds the J level (D+ high, D- low), and the kept level is J. The kept level is also forced to J in every cycle where `eop` is high. As a result, a K bit at the start of the next packet decodes as 0.
- R9: Random NRZI bit streams, whose bit boundaries are each shifted by up to one cycle either way, decode without error, with exactly one strobe per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, eight times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_raw | input | 1 | Unsynchronised D+ wire |
| dm_raw | input | 1 | Unsynchronised D- wire |
| rx_active | input | 1 | Enables the bit timer while a packet is expected |
| bit_strobe | output | 1 | One-cycle pulse marking the sample point of a bit |
| bit_value | output | 1 | NRZI-decoded bit, valid while `bit_strobe` is high |
| dp_edge | output | 1 | One-cycle pulse on any transition of synchronised D+ |
| eop | output | 1 | Single-ended-zero (end-of-packet) flag |

## Verification
A timer count that is off by one shows up at the ports at once as a strobe gap of 7 or 9 cycles, or as an edge-to-strobe distance other than 3. A count that is off by more moves the sample point onto a bit boundary within a few bits, and the decoded values then become wrong. A wrong kept level inverts the very next decoded bit. The first-bit test after every end-of-packet is built to expose a missed J reload within one bit. A fault in the synchroniser or edge register changes the number of `dp_edge` pulses or their latency, and the edge count checked at the end catches it.

// File: rtl/fs_bit_recover.sv
module fs_bit_recover #(
  parameter int TMR_W       = 4,
  parameter int BIT_CLKS    = 8,
  parameter int RESYNC_WAIT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dp_raw,
  input  logic dm_raw,
  input  logic rx_active,
  output logic bit_strobe,
  output logic bit_value,
  output logic dp_edge,
  output logic eop
);
  localparam logic [TMR_W-1:0] CNT_LAST   = TMR_W'(BIT_CLKS - 1);
  localparam logic [TMR_W-1:0] CNT_SAMPLE = TMR_W'(RESYNC_WAIT);
  localparam logic [TMR_W-1:0] CNT_LOAD   = TMR_W'(1);

  logic [1:0]       dp_sync, dm_sync;
  logic             dp_d, dp_last;
  logic [TMR_W-1:0] cnt_q;

  assign dp_edge    = dp_sync[1] ^ dp_d;
  assign eop        = ~(dp_sync[1] | dm_sync[1]);
  assign bit_strobe = rx_active && (cnt_q == CNT_SAMPLE);
  assign bit_value  = ~(dp_sync[1] ^ dp_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_sync <= 2'b11;
      dm_sync <= 2'b00;
      dp_d    <= 1'b1;
      dp_last <= 1'b1;
    end else begin
      dp_sync <= {dp_sync[0], dp_raw};
      dm_sync <= {dm_sync[0], dm_raw};
      dp_d    <= dp_sync[1];
      if (eop)
        dp_last <= 1'b1;
      else if (bit_strobe)
        dp_last <= dp_sync[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!rx_active)
      cnt_q <= '0;
    else if (dp_edge)
      cnt_q <= CNT_LOAD;
    else if (cnt_q == CNT_LAST)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + CNT_LOAD;
  end
endmodule

// File: rtl/fs_bit_recover_chk.sv
module fs_bit_recover_chk #(
  parameter int TMR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_active,
  input logic             bit_strobe,
  input logic             dp_edge,
  input logic             eop,
  input logic             dp_s,
  input logic             dp_last,
  input logic [TMR_W-1:0] cnt_q
);
  assert_resync_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_active && dp_edge) |=> (cnt_q == TMR_W'(1)));

  assert_strobe_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);

  assert_timer_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_active |=> (cnt_q == '0));

  assert_eop_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eop |=> dp_last);

  assert_track_sample_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && !eop) |=> (dp_last == $past(dp_s)));
endmodule

bind fs_bit_recover fs_bit_recover_chk #(.TMR_W(TMR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_active  (rx_active),
  .bit_strobe (bit_strobe),
  .dp_edge    (dp_edge),
  .eop        (eop),
  .dp_s       (dp_sync[1]),
  .dp_last    (dp_last),
  .cnt_q      (cnt_q)
);

// File: tb/sim_fs_bit_recover.sv
module sim_fs_bit_recover;
  logic clk = 1'b0, rst_n = 1'b0;
  logic dp_raw = 1'b1, dm_raw = 1'b0, rx_active = 1'b0;
  logic bit_strobe, bit_value, dp_edge, eop;

  always #4 clk = ~clk;

  fs_bit_recover u0 (
    .clk(clk), .rst_n(rst_n), .dp_raw(dp_raw), .dm_raw(dm_raw),
    .rx_active(rx_active), .bit_strobe(bit_strobe), .bit_value(bit_value),
    .dp_edge(dp_edge), .eop(eop)
  );

  int checks = 0, fails = 0;
  int exp_edges = 0, seen_edges = 0;
  int cyc = 0, edge_cyc = 0, last_cyc = 0;
  bit edge_pend = 0, have_last = 0, prev_edge = 0, done = 0;
  bit exp_q[$];
  bit exp_bit;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_line(input bit v);
    if (v != dp_raw) exp_edges++;
    dp_raw = v;
  endtask

  task automatic drive_bit(input bit b, inout bit lvl, input int cycles);
    if (!b) lvl = ~lvl;
    set_line(lvl);
    dm_raw = ~lvl;
    exp_q.push_back(b);
    repeat (cycles) @(negedge clk);
  endtask

  // Monitor: timing checks (R3, R4) and scoreboard of decoded bits (R5, R9)
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (dp_edge) begin
        seen_edges++;
        if (prev_edge) chk(0, "R1 edge pulse wider than one cycle", 2, 1);
        edge_cyc  = cyc;
        edge_pend = 1;
      end
      prev_edge = dp_edge;
      if (bit_strobe) begin
        chk(rx_active, "R7 strobe while inactive", bit_strobe, 0);
        if (edge_pend)
          chk(cyc - edge_cyc == 3, "R4 edge-to-strobe distance", cyc - edge_cyc, 3);
        else if (have_last)
          chk(cyc - last_cyc == 8, "R3 strobe spacing", cyc - last_cyc, 8);
        edge_pend = 0;
        have_last = 1;
        last_cyc  = cyc;
        if (exp_q.size() == 0)
          chk(0, "R9 unexpected strobe", 1, 0);
        else begin
          exp_bit = exp_q.pop_front();
          chk(bit_value == exp_bit, "R5 decoded bit", bit_value, exp_bit);
        end
      end
      if (!rx_active) have_last = 0;
    end
  end

  // R9: random NRZI packets with +/-1 cycle boundary jitter, closed by SE0 (R2, R8)
  task automatic send_packet(input int nbits);
    bit lvl = dp_raw;
    int jc = 0;
    rx_active = 1'b1;
    for (int k = 0; k < nbits; k++) begin
      bit b = (k == 0) ? 1'b0 : 1'($urandom_range(0, 1));
      int jn = int'($urandom_range(0, 2)) - 1;
      drive_bit(b, lvl, 8 + jn - jc);
      jc = jn;
    end
    // close on a K level so a missed J reload at EOP corrupts the next first bit (R8)
    if (lvl) drive_bit(1'b0, lvl, 8 - jc);
    else begin
      drive_bit(1'b1, lvl, 8 - jc);
    end
    rx_active = 1'b0;
    set_line(1'b0);
    dm_raw = 1'b0;
    repeat (3) @(negedge clk);
    chk(eop == 1'b1, "R2 eop during SE0", eop, 1);
    repeat (13) @(negedge clk);
    chk(eop == 1'b1, "R2 eop held through SE0", eop, 1);
    set_line(1'b1);
    dm_raw = 1'b0;
    repeat (3) @(negedge clk);
    chk(eop == 1'b0, "R2 eop released at J", eop, 0);
    repeat (8) @(negedge clk);
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    chk(!bit_strobe && !dp_edge && !eop, "R8 reset outputs idle",
        {bit_strobe, dp_edge, eop}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!dp_edge && !eop, "R8 J level after reset", {dp_edge, eop}, 0);

    // R7: activation on an idle J line, first strobe in 4th active cycle
    rx_active = 1'b1;
    repeat (3) exp_q.push_back(1'b1);
    repeat (2) @(negedge clk);
    chk(bit_strobe == 1'b0, "R7 no early strobe", bit_strobe, 0);
    @(negedge clk);
    chk(bit_strobe == 1'b1, "R7 first strobe after activation", bit_strobe, 1);
    repeat (20) @(negedge clk);
    rx_active = 1'b0;
    s = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (bit_strobe) s++;
    end
    chk(s == 0, "R7 no strobes while inactive", s, 0);

    for (int p = 0; p < 20; p++) send_packet(24 + 2 * p);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R9 all bits strobed", exp_q.size(), 0);
    chk(seen_edges == exp_edges, "R1 edge pulse count", seen_edges, exp_edges);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule